// File: doc/BRIEF.md
# Blanking-Gated Frame-Buffer Pixel Writer

This block is a bus master that fills a video frame buffer one pixel at a time. It shares that memory with a display controller, which reads the same buffer to refresh the screen. Pixel colours come from a small two-port pattern memory of 2-bit codes. A separate drawing process can rewrite that memory while the writer runs. The writer steps through every pixel of the frame in raster order. It turns each pixel's code into an 8-bit colour and issues a single-pixel write. Each write is two cycles long, a write cycle followed by an acknowledge cycle.

A write may begin only inside a short safe window. The window is built from the display's active-low horizontal and vertical sync inputs. Each input passes through a two-flop synchroniser, and the leading (falling) edge of either pulse loads a stretch counter. The window stays open for a fixed number of cycles, which must be shorter than blanking. Whole-blanking gating is not used because it would let the second cycle of a write overlap the first active-video read. The stretch keeps the write rate close to what whole-blanking gating would give.

The pattern memory is addressed by the low bits of the pixel coordinates, so its contents tile across the frame.

Top module: `fb_pixel_writer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `bus_write` is 0. The first write issued after reset carries address 0.
- R2: A falling edge on `hsync_n` or `vsync_n` first sampled at clock edge k opens the window for write-start decisions at edges k+3 through k+2+WIN_LEN. A later edge reloads the window, so overlapping windows merge.
- R3: A write starts only on a clock edge where the writer is idle and the window is open. With both sync inputs held high, no write ever starts.
- R4: Once `bus_write` rises, it stays high with `bus_addr` and `bus_wdata` unchanged until the edge that samples `bus_ack` high. `bus_write` then drops for at least one cycle.
- R5: Each 2-bit code is written as an 8-bit colour with red in bits 7:5, green in bits 4:2 and blue in bits 1:0. The mapping is 0→0x00 (black), 1→0xE0 (red), 2→0x1C (green), 3→0x03 (blue).
- R6: Write addresses follow the linear pixel index y*H_PIX + x in raster order. x wraps from H_PIX-1 to 0 and y then increments; after pixel H_PIX*V_PIX-1 the next write goes to address 0.
- R7: The code for pixel (x,y) is read from pattern entry {y[TILE_YB-1:0], x[TILE_XB-1:0]}. A drawing write on the same clock edge as the read returns the old contents.
- R8: A sync input that is held low, or that rises, opens no further window: only its falling edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_n | input | 1 | Horizontal sync from the display timing, active low, asynchronous |
| vsync_n | input | 1 | Vertical sync from the display timing, active low, asynchronous |
| draw_we | input | 1 | Drawing-process write enable into the pattern memory |
| draw_addr | input | TILE_XB+TILE_YB | Pattern memory entry to write |
| draw_code | input | 2 | 2-bit colour code to store |
| bus_ack | input | 1 | Write acknowledge from the memory bus |
| bus_write | output | 1 | Write request, held until acknowledged |
| bus_addr | output | clog2(H_PIX*V_PIX) | Pixel byte address in the frame buffer |
| bus_wdata | output | 8 | 8-bit colour of the pixel being written |

## Verification
The bench builds the writer as a 10x4 frame with a 4x4 pattern tile (TILE_XB = TILE_YB = 2) and a window of 5 cycles. These values let a whole frame, including the wrap from the last pixel back to address 0, pass many times in a few thousand cycles. They also make the tile repeat more than once along each row. At an acknowledge latency of 2 cycles, a 5-cycle window holds exactly two write starts, and two edges four cycles apart hold exactly three. Any error of one cycle in the synchroniser depth, the window length or the reload therefore changes a count the bench predicts. A second phase lengthens the acknowledge to 4 cycles while the drawing port rewrites the tile at random, to cover held writes and read-before-write collisions.

// File: rtl/fbw_pkg.sv
// Shared types and the code-to-colour mapping for the frame-buffer pixel writer.
// Assumes an 8-bit 3-3-2 RGB pixel format and 2-bit pattern codes.
package fbw_pkg;

    localparam int CODE_W  = 2;
    localparam int COLOR_W = 8;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;

    // Expand a 2-bit pattern code into a 3-3-2 RGB byte.
    function automatic logic [COLOR_W-1:0] code_to_rgb332(input logic [CODE_W-1:0] code);
        logic [2:0] red;
        logic [2:0] grn;
        logic [1:0] blu;
        red = (code == 2'd1) ? 3'b111 : 3'b000;
        grn = (code == 2'd2) ? 3'b111 : 3'b000;
        blu = (code == 2'd3) ? 2'b11  : 2'b00;
        return {red, grn, blu};
    endfunction

endpackage

// File: rtl/fbw_sync_window.sv
// Write-window generator. Synchronises the two active-low sync inputs and
// detects their falling edges. Each edge reloads a stretch counter, and the
// window is open while that counter is non-zero.
// Assumes sync inputs idle high and WIN_LEN shorter than the blanking interval.
module fbw_sync_window #(
    parameter int WIN_LEN     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_n,
    input  logic vsync_n,
    output logic sync_edge,
    output logic win_open
);

    localparam int NSYNC = 2;
    localparam int CW    = $clog2(WIN_LEN + 1);

    // stage 0..SYNC_STAGES-1 form the synchroniser, the last stage holds the previous level
    logic [SYNC_STAGES:0][NSYNC-1:0] pipe;
    logic [CW-1:0]                   hold_cnt;
    logic [NSYNC-1:0]                fall;

    // Shift both sync inputs through the synchroniser and the edge-history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[SYNC_STAGES-1:0], {vsync_n, hsync_n}};
        end
    end

    // A falling edge is an old high level followed by a new low level.
    always_comb begin
        fall      = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];
        sync_edge = |fall;
    end

    // Reload the stretch counter on any leading edge, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (sync_edge) begin
            hold_cnt <= CW'(WIN_LEN);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - CW'(1);
        end
    end

    assign win_open = (hold_cnt != '0);

endmodule

// File: rtl/fbw_code_ram.sv
// Two-port pattern memory of colour codes. One port is written by the drawing
// process; the other is read by the writer with a one-cycle registered output.
// A read and a write to the same entry on one edge return the old contents.
module fbw_code_ram #(
    parameter int AW = 10,
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Drawing-side write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Writer-side registered read port.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/fbw_raster.sv
// Raster position tracker. Holds the current x, y and linear pixel index and
// advances all three by one pixel when step is high, wrapping at the frame end.
// It also exposes the next position so a registered memory read can fetch ahead.
module fbw_raster #(
    parameter int H_PIX = 640,
    parameter int V_PIX = 480
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step,
    output logic [$clog2(H_PIX*V_PIX)-1:0]  cur_lin,
    output logic [$clog2(H_PIX)-1:0]        nxt_x,
    output logic [$clog2(V_PIX)-1:0]        nxt_y
);

    localparam int XW = $clog2(H_PIX);
    localparam int YW = $clog2(V_PIX);
    localparam int LW = $clog2(H_PIX * V_PIX);
    localparam logic [XW-1:0] X_LAST = XW'(H_PIX - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(V_PIX - 1);
    localparam logic [LW-1:0] L_LAST = LW'(H_PIX * V_PIX - 1);

    logic [XW-1:0] pos_x;
    logic [YW-1:0] pos_y;
    logic [LW-1:0] nxt_lin;

    // Work out the position after this cycle, wrapping x, then y, then the index.
    always_comb begin
        nxt_x   = pos_x;
        nxt_y   = pos_y;
        nxt_lin = cur_lin;
        if (step) begin
            if (pos_x == X_LAST) begin
                nxt_x = '0;
                nxt_y = (pos_y == Y_LAST) ? '0 : pos_y + YW'(1);
            end else begin
                nxt_x = pos_x + XW'(1);
            end
            nxt_lin = (cur_lin == L_LAST) ? '0 : cur_lin + LW'(1);
        end
    end

    // Register the raster position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x   <= '0;
            pos_y   <= '0;
            cur_lin <= '0;
        end else begin
            pos_x   <= nxt_x;
            pos_y   <= nxt_y;
            cur_lin <= nxt_lin;
        end
    end

endmodule

// File: rtl/fb_pixel_writer.sv
// Frame-buffer pixel writer. Sweeps the frame in raster order and, for each
// pixel, expands its pattern code to a 3-3-2 colour. It issues a single write
// held until acknowledged. A write starts only when idle and the sync-derived
// window is open. Assumes the bus slave raises bus_ack while bus_write is high
// and the pattern tile fits inside the coordinate widths.
module fb_pixel_writer
    import fbw_pkg::*;
#(
    parameter int H_PIX   = 640,
    parameter int V_PIX   = 480,
    parameter int TILE_XB = 5,
    parameter int TILE_YB = 5,
    parameter int WIN_LEN = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               hsync_n,
    input  logic                               vsync_n,
    input  logic                               draw_we,
    input  logic [TILE_XB+TILE_YB-1:0]         draw_addr,
    input  logic [1:0]                         draw_code,
    input  logic                               bus_ack,
    output logic                               bus_write,
    output logic [$clog2(H_PIX*V_PIX)-1:0]     bus_addr,
    output logic [7:0]                         bus_wdata
);

    localparam int XW  = $clog2(H_PIX);
    localparam int YW  = $clog2(V_PIX);
    localparam int LW  = $clog2(H_PIX * V_PIX);
    localparam int TAW = TILE_XB + TILE_YB;

    wr_state_e       state;
    logic            win_open;
    logic            sync_edge;
    logic            step;
    logic [LW-1:0]   cur_lin;
    logic [XW-1:0]   nxt_x;
    logic [YW-1:0]   nxt_y;
    logic [TAW-1:0]  tile_idx;
    logic [CODE_W-1:0] rd_code;

    fbw_sync_window #(
        .WIN_LEN (WIN_LEN)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .sync_edge (sync_edge),
        .win_open  (win_open)
    );

    fbw_raster #(
        .H_PIX (H_PIX),
        .V_PIX (V_PIX)
    ) u_raster (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .cur_lin (cur_lin),
        .nxt_x   (nxt_x),
        .nxt_y   (nxt_y)
    );

    // Fetch ahead: read the tile entry of the position the raster holds next cycle.
    assign tile_idx = {nxt_y[TILE_YB-1:0], nxt_x[TILE_XB-1:0]};

    fbw_code_ram #(
        .AW (TAW),
        .DW (CODE_W)
    ) u_codes (
        .clk     (clk),
        .wr_en   (draw_we),
        .wr_addr (draw_addr),
        .wr_data (draw_code),
        .rd_addr (tile_idx),
        .rd_data (rd_code)
    );

    // Advance the raster once the current pixel's write is acknowledged.
    assign step      = (state == WR_BUSY) && bus_ack;
    assign bus_write = (state == WR_BUSY);

    // Start a write in an open window, hold it until acknowledged, then rest a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WR_IDLE;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            case (state)
                WR_IDLE: begin
                    if (win_open) begin
                        state     <= WR_BUSY;
                        bus_addr  <= cur_lin;
                        bus_wdata <= code_to_rgb332(rd_code);
                    end
                end
                WR_BUSY: begin
                    if (bus_ack) begin
                        state <= WR_IDLE;
                    end
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fbw_checker.sv
// Protocol and timing checker for the frame-buffer pixel writer, bound to the
// top module. Watches the bus outputs and the window generator's outputs.
module fbw_checker #(
    parameter int H_PIX   = 640,
    parameter int V_PIX   = 480,
    parameter int WIN_LEN = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_write,
    input logic                           bus_ack,
    input logic [$clog2(H_PIX*V_PIX)-1:0] bus_addr,
    input logic [7:0]                     bus_wdata,
    input logic                           win_open,
    input logic                           sync_edge
);

    int win_run;

    // Count open-window cycles since the last sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_run <= 0;
        end else if (sync_edge) begin
            win_run <= 0;
        end else if (win_open) begin
            win_run <= win_run + 1;
        end else begin
            win_run <= 0;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !bus_write);

    // R2
    window_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(sync_edge));

    // R2
    window_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> (win_run < WIN_LEN));

    // R3
    start_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_write) |-> $past(win_open));

    // R4
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && !bus_ack) |=> (bus_write && $stable(bus_addr) && $stable(bus_wdata)));

    // R4
    release_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && bus_ack) |=> !bus_write);

    // R5
    legal_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write |-> (bus_wdata == 8'h00 || bus_wdata == 8'hE0 ||
                       bus_wdata == 8'h1C || bus_wdata == 8'h03));

    // R6
    addr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_write |-> (int'(bus_addr) < H_PIX * V_PIX));

endmodule

bind fb_pixel_writer fbw_checker #(
    .H_PIX   (H_PIX),
    .V_PIX   (V_PIX),
    .WIN_LEN (WIN_LEN)
) u_fbw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_write (bus_write),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .win_open  (win_open),
    .sync_edge (sync_edge)
);

// File: tb/test_fb_pixel_writer.sv
module test_fb_pixel_writer;

    localparam int H   = 10;
    localparam int V   = 4;
    localparam int TXB = 2;
    localparam int TYB = 2;
    localparam int WL  = 5;
    localparam int AW  = $clog2(H * V);
    localparam int CAW = TXB + TYB;
    localparam int NPIX = H * V;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           hsync_n;
    logic           vsync_n;
    logic           draw_we;
    logic [CAW-1:0] draw_addr;
    logic [1:0]     draw_code;
    logic           bus_ack;
    logic           bus_write;
    logic [AW-1:0]  bus_addr;
    logic [7:0]     bus_wdata;

    always #4 clk = ~clk;

    fb_pixel_writer #(
        .H_PIX   (H),
        .V_PIX   (V),
        .TILE_XB (TXB),
        .TILE_YB (TYB),
        .WIN_LEN (WL)
    ) i_fb_pixel_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .draw_we   (draw_we),
        .draw_addr (draw_addr),
        .draw_code (draw_code),
        .bus_ack   (bus_ack),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    int vectors = 0;
    int misses  = 0;
    bit chk_on  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int color_of(input int code);
        case (code)
            0:       return 'h00;
            1:       return 'hE0;
            2:       return 'h1C;
            default: return 'h03;
        endcase
    endfunction

    function automatic int tile_of(input int x, input int y);
        return ((y % (1 << TYB)) << TXB) + (x % (1 << TXB));
    endfunction

    // ---------------- bus slave: acknowledge after ack_lat write cycles ----------------
    int ack_lat = 2;
    int wcnt    = 0;
    always @(negedge clk) begin
        if (!bus_write) begin
            wcnt = 0;
            bus_ack <= 1'b0;
        end else begin
            wcnt = wcnt + 1;
            bus_ack <= (wcnt == ack_lat);
        end
    end

    // ---------------- behavioural reference model, advanced on each edge ----------------
    longint edge_no = 0;
    longint falls[$];
    bit     prev_h, prev_v;
    bit     m_wr;
    int     m_x, m_y, m_lin, m_addr, m_data, m_rd;
    int     mem [1 << CAW];
    bit     open_now;

    initial begin
        for (int i = 0; i < (1 << CAW); i++) mem[i] = 0;
    end

    always @(posedge clk) begin
        edge_no++;
        if (!rst_n) begin
            falls.delete();
            prev_h = 1; prev_v = 1;
            m_wr = 0; m_x = 0; m_y = 0; m_lin = 0; m_addr = 0; m_data = 0;
            m_rd = mem[0];
        end else begin
            open_now = 0;
            foreach (falls[i]) begin
                if (edge_no - falls[i] >= 3 && edge_no - falls[i] <= WL + 2) open_now = 1;
            end
            if (prev_h && !hsync_n) falls.push_back(edge_no);
            if (prev_v && !vsync_n) falls.push_back(edge_no);
            prev_h = hsync_n;
            prev_v = vsync_n;
            while (falls.size() > 0 && edge_no - falls[0] > WL + 2) void'(falls.pop_front());

            if (!m_wr) begin
                if (open_now) begin
                    m_wr   = 1;
                    m_addr = m_lin;
                    m_data = color_of(m_rd);
                end
            end else if (bus_ack) begin
                m_wr  = 0;
                m_lin = (m_lin + 1) % NPIX;
                m_x   = m_x + 1;
                if (m_x == H) begin
                    m_x = 0;
                    m_y = (m_y + 1) % V;
                end
            end
            m_rd = mem[tile_of(m_x, m_y)];
            if (draw_we) mem[int'(draw_addr)] = int'(draw_code);
        end
    end

    // ---------------- per-cycle comparison and start monitor ----------------
    int  starts     = 0;
    bit  prev_w     = 0;
    int  exp_start  = 0;
    bit  first_seen = 0;
    bit  wrapped    = 0;

    always @(negedge clk) begin
        if (chk_on) begin
            check(bus_write == m_wr, "R3/R4 write strobe", int'(bus_write), int'(m_wr));
            if (bus_write && m_wr) begin
                check(int'(bus_addr) == m_addr, "R6 address", int'(bus_addr), m_addr);
                check(int'(bus_wdata) == m_data, "R5/R7 colour", int'(bus_wdata), m_data);
            end
            if (bus_write && !prev_w) begin
                starts++;
                if (!first_seen) begin
                    first_seen = 1;
                    check(bus_addr == '0, "R1 first address", int'(bus_addr), 0);
                end
                check(int'(bus_addr) == exp_start, "R6 raster order", int'(bus_addr), exp_start);
                if (exp_start == 0 && starts > 1) wrapped = 1;
                exp_start = (int'(bus_addr) + 1) % NPIX;
            end
            prev_w = bus_write;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int s0;
        rst_n     = 1'b0;
        hsync_n   = 1'b1;
        vsync_n   = 1'b1;
        draw_we   = 1'b0;
        draw_addr = '0;
        draw_code = '0;
        repeat (5) @(negedge clk);
        // R1: outputs idle during reset
        check(bus_write == 1'b0, "R1 reset write", int'(bus_write), 0);
        check(bus_addr == '0, "R1 reset address", int'(bus_addr), 0);
        rst_n <= 1'b1;
        @(negedge clk);
        chk_on = 1;
        check(bus_write == 1'b0, "R1 after reset", int'(bus_write), 0);

        // Load the tile with syncs idle: R3 no writes without a window.
        s0 = starts;
        for (int i = 0; i < (1 << CAW); i++) begin
            draw_we   <= 1'b1;
            draw_addr <= CAW'(i);
            draw_code <= 2'((i * 3 + i / 4) % 4);
            @(negedge clk);
        end
        draw_we <= 1'b0;
        repeat (20) @(negedge clk);
        check(starts == s0, "R3 no window no write", starts - s0, 0);

        // R2: one short hsync pulse opens one window: two starts at ack latency 2.
        s0 = starts;
        hsync_n <= 1'b0;
        repeat (2) @(negedge clk);
        hsync_n <= 1'b1;
        repeat (30) @(negedge clk);
        check(starts - s0 == 2, "R2 single edge window", starts - s0, 2);

        // R8: vsync held low then released: only its falling edge counts.
        s0 = starts;
        vsync_n <= 1'b0;
        repeat (40) @(negedge clk);
        vsync_n <= 1'b1;
        repeat (30) @(negedge clk);
        check(starts - s0 == 2, "R8 held low and rising edge", starts - s0, 2);

        // R2: hsync edge then vsync edge four cycles later merge into one longer window.
        s0 = starts;
        hsync_n <= 1'b0;
        repeat (4) @(negedge clk);
        vsync_n <= 1'b0;
        repeat (2) @(negedge clk);
        hsync_n <= 1'b1;
        vsync_n <= 1'b1;
        repeat (30) @(negedge clk);
        check(starts - s0 == 3, "R2 reload by second edge", starts - s0, 3);

        // Bulk run with concurrent drawing, acknowledge latency 2 (R4, R5, R6, R7).
        for (int c = 0; c < 1500; c++) begin
            hsync_n   <= (c % 16) >= 2;
            vsync_n   <= (c % 200) >= 3;
            draw_we   <= ($urandom % 4) == 0;
            draw_addr <= CAW'($urandom);
            draw_code <= 2'($urandom);
            @(negedge clk);
        end

        // Longer acknowledge, different sync spacing.
        ack_lat = 4;
        for (int c = 0; c < 1500; c++) begin
            hsync_n   <= (c % 24) >= 4;
            vsync_n   <= (c % 310) >= 2;
            draw_we   <= ($urandom % 3) == 0;
            draw_addr <= CAW'($urandom);
            draw_code <= 2'($urandom);
            @(negedge clk);
        end
        hsync_n <= 1'b1;
        vsync_n <= 1'b1;
        draw_we <= 1'b0;
        repeat (30) @(negedge clk);

        check(wrapped, "R6 frame wrap to address 0", int'(wrapped), 1);
        check(starts > NPIX * 2, "R3 bulk writes issued", starts, NPIX * 2);
        summary();
        $finish;
    end

endmodule